// File: doc/BRIEF.md
# Keyed System Control Register Bank

This block is the control and identification register file of a processor module. A host reaches it over a plain synchronous register bus: a word address, a write strobe, write data and a registered read-data return. It holds two oscillator setting words, a control word, a memory-configuration word, an initialisation word, two independent flag words, a free-running reference counter and a small byte table that describes the fitted memory. Both oscillator words are guarded by a 16-bit key register, so only a host that has first written the key can change them.

Two control bits leave the block as pins. One bit selects the boot memory map: the remap output is low while boot flash sits at address zero and high once RAM replaces it. A write to the control word that sets the reset trigger bit produces a reset-request pulse in the same cycle; that bit is never stored. The reference counter advances on each cycle in which the tick-enable input is high. This lets the integrating chip feed it from a divided reference clock, for example a 24 MHz enable.

Top module: `sysctl_bank`

## Requirements
- R1: After a synchronous reset, reads return these values: oscillator (word 2) 0x01000048, auxiliary oscillator (word 7) 0x0007FEFF, memory configuration (word 8) 0x00011122 with the size code of R10 ORed in, init (word 9) 0x00000112. The control, key, both flag words and the counter read 0. Remap and reset_req are low.
- R2: Word 0 reads the identification constant 0x411A3001 and word 4 reads the status constant 0x00100000.
- R3: A write to the key register (word 5) keeps only bits 15:0. While the stored key equals 0xA05F, a read of word 5 returns 0x0001A05F. Otherwise it returns the stored 16-bit value.
- R4: Writes to word 2 and word 7 update those registers only while the key register holds 0xA05F. At any other time the register keeps its value.
- R5: A write to the control word (word 3) stores bit 0 and bit 2 only. Bit 3 of a read of word 3 is always 0. A write with bit 3 set drives reset_req high for exactly that cycle, and reset_req is low in every other cycle.
- R6: The remap output follows control bit 2 from the clock edge that stores the write.
- R7: A write to word 12 ORs the data into the flag word. A write to word 13 clears every flag bit that is 1 in the data. The flag word reads back at word 12.
- R8: Words 14 (set) and 15 (clear) act the same way on a second flag word, which reads back at word 14 and is independent of the first.
- R9: The counter read at word 10 starts at 0, adds one on each clock edge at which tick_en is high, and holds while tick_en is low.
- R10: Parameter MEM_MB ORs a size code into the reset value of word 8: 0x10 for 256 or more, 0x0C for 128 or more, 0x08 for 64 or more, 0x04 for 32 or more, and nothing below 32. The default MEM_MB of 128 gives 0x0001112E.
- R11: Words 0x40 to 0x5F read one zero-extended byte of a memory description table. At words 0x49 to 0x53 that byte is the ASCII text "SYSCTL-DIMM", one character per word in order. The other words of this range read 0. Words 0x60 to 0x7F read 0.
- R12: bus_rdata shows the register addressed in the previous cycle, with the value that register held before any write in that same cycle. Words 8 and 9 are plain read/write storage. Every other word not listed, including words 1, 13, 15 and those at 0x80 and above, reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Word address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| tick_en | input | 1 | Reference counter advance enable |
| reset_req | output | 1 | One-cycle reset request |
| remap | output | 1 | High when RAM replaces boot flash at address zero |

## Verification
The hardest situation to reach is an oscillator write that is dropped. The host must first move the key away from 0xA05F, or never write it, then attempt the write. Only a later read can show that the register kept its old value. The stimulus opens the key, writes a known value, then closes the key with a nearby wrong value such as 0xA05E and writes again. This separates "ignored because locked" from "never written". The reset request is combinational, so its check samples mid-cycle, during the write itself.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

  localparam int unsigned W_IDENT   = 0;
  localparam int unsigned W_OSC     = 2;
  localparam int unsigned W_CTRL    = 3;
  localparam int unsigned W_STATUS  = 4;
  localparam int unsigned W_KEY     = 5;
  localparam int unsigned W_AUXOSC  = 7;
  localparam int unsigned W_MEMCFG  = 8;
  localparam int unsigned W_INIT    = 9;
  localparam int unsigned W_COUNT   = 10;
  localparam int unsigned W_FLG_SET = 12;
  localparam int unsigned W_FLG_CLR = 13;
  localparam int unsigned W_NVF_SET = 14;
  localparam int unsigned W_NVF_CLR = 15;
  localparam int unsigned W_TABLE   = 32'h40;

  localparam logic [31:0] IDENT_VAL  = 32'h411A_3001;
  localparam logic [31:0] STATUS_VAL = 32'h0010_0000;
  localparam logic [15:0] UNLOCK_KEY = 16'hA05F;
  localparam logic [31:0] KEY_OPEN_RD = {15'b0, 1'b1, UNLOCK_KEY};

  localparam logic [31:0] OSC_RST    = 32'h0100_0048;
  localparam logic [31:0] AUXOSC_RST = 32'h0007_FEFF;
  localparam logic [31:0] MEMCFG_RST = 32'h0001_1122;
  localparam logic [31:0] INIT_RST   = 32'h0000_0112;

  function automatic logic [31:0] size_code(input int mb);
    if (mb >= 256)      return 32'h10;
    else if (mb >= 128) return 32'h0C;
    else if (mb >= 64)  return 32'h08;
    else if (mb >= 32)  return 32'h04;
    else                return 32'h00;
  endfunction

endpackage

// File: rtl/sysctl_flagword.sv
module sysctl_flagword #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         set_stb,
  input  logic         clr_stb,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)          q <= '0;
    else if (set_stb) q <= q | wdata;
    else if (clr_stb) q <= q & ~wdata;
  end

  // Shared by both flag words: R7 and R8
  assert_flag_set_R7: assert property (@(posedge clk) disable iff (rst)
    set_stb |=> ((q & $past(wdata)) == $past(wdata)));
  assert_flag_clr_R8: assert property (@(posedge clk) disable iff (rst)
    (clr_stb && !set_stb) |=> ((q & $past(wdata)) == '0));
endmodule

// File: rtl/sysctl_refcount.sv
module sysctl_refcount #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (tick) cnt <= cnt + 1'b1;
  end

  assert_count_step_R9: assert property (@(posedge clk) disable iff (rst)
    tick |=> (cnt == $past(cnt) + 1'b1));
  assert_count_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(cnt));
endmodule

// File: rtl/sysctl_memdesc.sv
module sysctl_memdesc #(
  parameter int DEPTH = 32,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic [IW-1:0] idx,
  output logic [7:0]    data
);
  localparam logic [87:0] LABEL = "SYSCTL-DIMM";
  localparam int LABEL_OFF = 9;
  localparam int LABEL_LEN = 11;

  function automatic logic [7:0] entry(input int i);
    if (i >= LABEL_OFF && i < LABEL_OFF + LABEL_LEN)
      return LABEL[8*(LABEL_LEN-1-(i-LABEL_OFF)) +: 8];
    return 8'h00;
  endfunction

  always_comb data = entry(int'(idx));
endmodule

// File: rtl/sysctl_bank.sv
module sysctl_bank
  import sysctl_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int MEM_MB    = 128,
  parameter int CNT_W     = 32,
  parameter int TBL_DEPTH = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              tick_en,
  output logic              reset_req,
  output logic              remap
);
  localparam int TBL_IW = $clog2(TBL_DEPTH);
  localparam logic [31:0] MEMCFG_INIT = MEMCFG_RST | size_code(MEM_MB);

  logic [31:0] word_idx;
  logic [31:0] osc_q, aux_q, memcfg_q, init_q, flg_q, nvf_q;
  logic [15:0] key_q;
  logic        ctrl0_q;
  logic [CNT_W-1:0] cnt_q;
  logic [7:0]  tbl_byte;
  logic        key_open, in_table;
  logic [31:0] rd_next;

  assign word_idx = 32'(bus_addr);
  assign key_open = (key_q == UNLOCK_KEY);
  assign in_table = (word_idx >= W_TABLE) && (word_idx < W_TABLE + TBL_DEPTH);

  sysctl_flagword #(.W(32)) u_flags (
    .clk(clk), .rst(rst),
    .set_stb(bus_wr && word_idx == W_FLG_SET),
    .clr_stb(bus_wr && word_idx == W_FLG_CLR),
    .wdata(bus_wdata), .q(flg_q));

  sysctl_flagword #(.W(32)) u_nvflags (
    .clk(clk), .rst(rst),
    .set_stb(bus_wr && word_idx == W_NVF_SET),
    .clr_stb(bus_wr && word_idx == W_NVF_CLR),
    .wdata(bus_wdata), .q(nvf_q));

  sysctl_refcount #(.W(CNT_W)) u_count (
    .clk(clk), .rst(rst), .tick(tick_en), .cnt(cnt_q));

  sysctl_memdesc #(.DEPTH(TBL_DEPTH)) u_table (
    .idx(bus_addr[TBL_IW-1:0]), .data(tbl_byte));

  assign reset_req = !rst && bus_wr && (word_idx == W_CTRL) && bus_wdata[3];

  always_ff @(posedge clk) begin
    if (rst) begin
      osc_q    <= OSC_RST;
      aux_q    <= AUXOSC_RST;
      memcfg_q <= MEMCFG_INIT;
      init_q   <= INIT_RST;
      key_q    <= '0;
      ctrl0_q  <= 1'b0;
      remap    <= 1'b0;
    end else if (bus_wr) begin
      case (word_idx)
        W_OSC:    if (key_open) osc_q <= bus_wdata;
        W_AUXOSC: if (key_open) aux_q <= bus_wdata;
        W_CTRL: begin
          ctrl0_q <= bus_wdata[0];
          remap   <= bus_wdata[2];
        end
        W_KEY:    key_q    <= bus_wdata[15:0];
        W_MEMCFG: memcfg_q <= bus_wdata;
        W_INIT:   init_q   <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_next = '0;
    if (in_table) rd_next = {24'b0, tbl_byte};
    else begin
      case (word_idx)
        W_IDENT:   rd_next = IDENT_VAL;
        W_STATUS:  rd_next = STATUS_VAL;
        W_OSC:     rd_next = osc_q;
        W_AUXOSC:  rd_next = aux_q;
        W_CTRL:    rd_next = {29'b0, remap, 1'b0, ctrl0_q};
        W_KEY:     rd_next = key_open ? KEY_OPEN_RD : {16'b0, key_q};
        W_MEMCFG:  rd_next = memcfg_q;
        W_INIT:    rd_next = init_q;
        W_COUNT:   rd_next = 32'(cnt_q);
        W_FLG_SET: rd_next = flg_q;
        W_NVF_SET: rd_next = nvf_q;
        default:   rd_next = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_next;
  end

  assert_osc_locked_R4: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && word_idx == W_OSC && key_q != UNLOCK_KEY) |=> $stable(osc_q));
  assert_aux_locked_R4: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && word_idx == W_AUXOSC && key_q != UNLOCK_KEY) |=> $stable(aux_q));
  assert_key_read_R3: assert property (@(posedge clk) disable iff (rst)
    (word_idx == W_KEY && key_q == UNLOCK_KEY) |=> (bus_rdata == KEY_OPEN_RD));
  assert_trigger_reads_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (word_idx == W_CTRL) |=> !bus_rdata[3]);
  assert_remap_follows_R6: assert property (@(posedge clk) disable iff (rst)
    reset_req |=> (remap == $past(bus_wdata[2])));
  assert_high_words_zero_R12: assert property (@(posedge clk) disable iff (rst)
    (word_idx >= 32'h80) |=> (bus_rdata == '0));
endmodule

// File: tb/sim_sysctl_bank.sv
`timescale 1ns/1ps
module sim_sysctl_bank;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tick_en = 1'b0;
  logic        reset_req, remap;

  int n_cmp = 0;
  int n_bad = 0;
  int pcnt = 0;
  bit finished = 0;

  int          stamp_q[$];
  logic [31:0] exp_q[$];
  logic [7:0]  adr_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;
  always @(posedge clk) pcnt <= pcnt + 1;

  sysctl_bank u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_en(tick_en),
    .reset_req(reset_req), .remap(remap));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // monitor: pops every expectation whose read has been registered
  initial forever begin
    @(negedge clk);
    while (stamp_q.size() > 0 && stamp_q[0] < pcnt) begin
      void'(stamp_q.pop_front());
      check($sformatf("%s word 0x%02h", tag_q.pop_front(), adr_q.pop_front()),
            bus_rdata, exp_q.pop_front());
    end
  end

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(posedge clk); #2;
    bus_wr = 1'b0; bus_addr = a;
    stamp_q.push_back(pcnt); exp_q.push_back(exp);
    adr_q.push_back(a); tag_q.push_back(tag);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic exp_req);
    @(posedge clk); #2;
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    #8 check("R5 reset_req", {31'b0, reset_req}, {31'b0, exp_req});
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2; bus_wr = 1'b0;
    end
  endtask

  task automatic ticks(input int n);
    @(posedge clk); #2; bus_wr = 1'b0; tick_en = 1'b1;
    repeat (n) @(posedge clk);
    #2 tick_en = 1'b0;
  endtask

  initial begin
    #4000000;
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;
    #8;
    check("R1 remap after reset", {31'b0, remap}, 32'h0);
    check("R1 reset_req after reset", {31'b0, reset_req}, 32'h0);
    // R1, R10 reset values
    rd(8'd2,  32'h0100_0048, "R1 osc");
    rd(8'd7,  32'h0007_FEFF, "R1 auxosc");
    rd(8'd8,  32'h0001_112E, "R10 memcfg");
    rd(8'd9,  32'h0000_0112, "R1 init");
    rd(8'd12, 32'h0, "R1 flags");
    rd(8'd14, 32'h0, "R1 nvflags");
    rd(8'd10, 32'h0, "R1 counter");
    rd(8'd5,  32'h0, "R1 key");
    rd(8'd3,  32'h0, "R1 ctrl");
    // R2 constants
    rd(8'd0, 32'h411A_3001, "R2 ident");
    rd(8'd4, 32'h0010_0000, "R2 status");
    // R4 locked writes dropped
    wr(8'd2, 32'hDEAD_BEEF, 1'b0);
    wr(8'd7, 32'h1234_5678, 1'b0);
    rd(8'd2, 32'h0100_0048, "R4 osc locked");
    rd(8'd7, 32'h0007_FEFF, "R4 aux locked");
    // R3 key and unlocked writes
    wr(8'd5, 32'hFFFF_A05F, 1'b0);
    rd(8'd5, 32'h0001_A05F, "R3 key open");
    wr(8'd2, 32'hCAFE_F00D, 1'b0);
    wr(8'd7, 32'h0BAD_C0DE, 1'b0);
    rd(8'd2, 32'hCAFE_F00D, "R4 osc open");
    rd(8'd7, 32'h0BAD_C0DE, "R4 aux open");
    wr(8'd5, 32'h0001_A05E, 1'b0);
    rd(8'd5, 32'h0000_A05E, "R3 key low half");
    wr(8'd2, 32'h1111_1111, 1'b0);
    rd(8'd2, 32'hCAFE_F00D, "R4 osc relocked");
    // R5, R6 control
    wr(8'd3, 32'hFFFF_FFFF, 1'b1);
    rd(8'd3, 32'h0000_0005, "R5 ctrl masked");
    #8 check("R6 remap set", {31'b0, remap}, 32'h1);
    wr(8'd3, 32'h0000_0001, 1'b0);
    rd(8'd3, 32'h0000_0001, "R5 ctrl bit0");
    #8 check("R6 remap clear", {31'b0, remap}, 32'h0);
    wr(8'd3, 32'h0000_0008, 1'b1);
    rd(8'd3, 32'h0, "R5 trigger not stored");
    #8 check("R5 reset_req one cycle", {31'b0, reset_req}, 32'h0);
    // R7 flags
    wr(8'd12, 32'h0000_00F0, 1'b0);
    wr(8'd12, 32'h0F0F_0000, 1'b0);
    rd(8'd12, 32'h0F0F_00F0, "R7 flag set");
    wr(8'd13, 32'h0F00_0030, 1'b0);
    rd(8'd12, 32'h000F_00C0, "R7 flag clear");
    rd(8'd13, 32'h0, "R12 clear word reads 0");
    // R8 second flag word
    wr(8'd14, 32'h0000_00A5, 1'b0);
    wr(8'd15, 32'h0000_0005, 1'b0);
    rd(8'd14, 32'h0000_00A0, "R8 nvflags");
    rd(8'd12, 32'h000F_00C0, "R8 independent");
    rd(8'd15, 32'h0, "R12 nv clear word reads 0");
    // R9 counter
    ticks(5);
    rd(8'd10, 32'd5, "R9 count after 5 ticks");
    idle(3);
    rd(8'd10, 32'd5, "R9 count holds");
    ticks(2);
    rd(8'd10, 32'd7, "R9 count resumes");
    // R11 table window
    rd(8'h49, 32'h53, "R11 table S");
    rd(8'h4A, 32'h59, "R11 table Y");
    rd(8'h4F, 32'h2D, "R11 table dash");
    rd(8'h53, 32'h4D, "R11 table last M");
    rd(8'h48, 32'h0, "R11 table before text");
    rd(8'h54, 32'h0, "R11 table after text");
    rd(8'h60, 32'h0, "R11 upper window");
    // R12 storage, unmapped words, read-before-write
    wr(8'd8, 32'h1357_9BDF, 1'b0);
    wr(8'd9, 32'h2468_ACE0, 1'b0);
    rd(8'd8, 32'h1357_9BDF, "R12 memcfg storage");
    rd(8'd9, 32'h2468_ACE0, "R12 init storage");
    wr(8'h80, 32'hFFFF_FFFF, 1'b0);
    wr(8'd11, 32'hFFFF_FFFF, 1'b0);
    rd(8'h80, 32'h0, "R12 high word");
    rd(8'd11, 32'h0, "R12 unmapped word");
    rd(8'd1, 32'h0, "R12 word 1");
    rd(8'd2, 32'hCAFE_F00D, "R12 osc untouched");
    // read of a word in the same cycle it is written shows the old value
    @(posedge clk); #2;
    bus_wr = 1'b1; bus_addr = 8'd9; bus_wdata = 32'h0000_0001;
    stamp_q.push_back(pcnt); exp_q.push_back(32'h2468_ACE0);
    adr_q.push_back(8'd9); tag_q.push_back("R12 read before write");
    rd(8'd9, 32'h0000_0001, "R12 written value");
    idle(4);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule